// File: doc/BRIEF.md
# Repeated Port Block Transfer Sequencer

This block moves a run of equal-sized elements between one fixed I/O port and a range of memory, in either direction, on behalf of a repeated string I/O operation. A one-cycle start pulse latches a complete job: the transfer direction, the element size, a pointer direction flag, a 16-bit port number, a starting memory pointer and an element count. After that, the block runs without further help until the count is exhausted.

Each element is a pair of bus cycles, and only one bus is active at a time. On an input job, the block reads the port and then writes that value to memory at the current pointer. On an output job, it reads memory at the current pointer and then writes that value to the port. Both buses use a valid/ready handshake. After the second handshake of an element, the pointer moves by the element size, up or down, and the count drops by one.

When the job ends, a one-cycle completion pulse is raised. The final pointer and the remaining count stay on the outputs until the next start. A flag reports a port number that is not naturally aligned for the element size. The element is still sent as a single access.

Top module: `rep_port_xfer`

## Requirements
- R1: A start pulse seen while the block is idle latches the job, and `busy` is high from the next cycle until the completion cycle inclusive. A start pulse seen while `busy` is high is ignored and does not change the running job's results.
- R2: The size code selects the element width: 0 means 1 byte, 1 means 2 bytes, and 2 or 3 mean 4 bytes. After each element the pointer changes by exactly that many bytes.
- R3: With the direction flag at 0 the pointer increases after each element; with it at 1 the pointer decreases. Every memory access of an element uses the pointer value held before that element's step, and the pointer wraps modulo 2^32.
- R4: On an input job (`dirOut`=0), each element is a port read (`portWrite`=0) followed by a memory write (`memWrite`=1). The memory write carries the data returned by the port read.
- R5: On an output job (`dirOut`=1), each element is a memory read (`memWrite`=0) followed by a port write (`portWrite`=1). The port write carries the data returned by the memory read.
- R6: `portValid` and `memValid` are never high together. A raised valid stays high until its ready is seen. The port number presented is the latched one and stays constant for the whole job.
- R7: Exactly `count` elements are moved, and `countFinal` is 0 at completion. A start with count 0 makes no bus access and completes in the cycle after the start.
- R8: `done` is high for exactly one cycle per job. `ptrFinal`, `countFinal` and `misalign` hold their values after completion until the next accepted start.
- R9: `misalign` is 1 when the size is 2 bytes and the port number is odd, or when the size is 4 bytes and its two low bits are not 00. Otherwise it is 0. The transfer goes ahead in either case.
- R10: Data written to either bus is zero above the element width. Bits of the returned read data above the element width are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Job start pulse |
| dirOut | input | 1 | 1 = memory to port, 0 = port to memory |
| sizeSel | input | 2 | Element size code |
| downFlag | input | 1 | 1 = pointer decreases |
| portNum | input | 16 | Port number |
| ptrStart | input | 32 | Starting memory pointer |
| countStart | input | 32 | Element count |
| portValid | output | 1 | Port access request |
| portWrite | output | 1 | Port access is a write |
| portAddr | output | 16 | Port number of the access |
| portSize | output | 2 | Size code of the port access |
| portWdata | output | 32 | Port write data |
| portReady | input | 1 | Port accepts the access |
| portRdata | input | 32 | Port read data, sampled with ready |
| memValid | output | 1 | Memory access request |
| memWrite | output | 1 | Memory access is a write |
| memAddr | output | 32 | Memory byte address |
| memSize | output | 2 | Size code of the memory access |
| memWdata | output | 32 | Memory write data |
| memReady | input | 1 | Memory accepts the access |
| memRdata | input | 32 | Memory read data, sampled with ready |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| misalign | output | 1 | Port number misaligned for the size |
| ptrFinal | output | 32 | Current/final pointer |
| countFinal | output | 32 | Current/final remaining count |

## Verification
A wrong sequencer state shows at the very next handshake. The bus whose valid appears, or the write flag it carries, no longer matches the job direction and the element's phase. A pointer or step fault shows in the memory address of the following element, one element after the fault. A count fault shows as one element too many or too few before `done`, or as a nonzero `countFinal` in the completion cycle. Lost or unmasked data shows in the second access of the same element.

// File: rtl/rpx_pkg.sv
package rpx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2,
    ST_FIN    = 2'd3
  } seqState_t;

  typedef struct packed {
    logic loadCfg;
    logic captureData;
    logic stepElem;
  } dpStrobe_t;

  // element width in bytes for a size code (2 and 3 both mean four bytes)
  function automatic logic [2:0] elemBytes(input logic [1:0] code);
    case (code)
      2'd0:    elemBytes = 3'd1;
      2'd1:    elemBytes = 3'd2;
      default: elemBytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/rpx_control.sv
module rpx_control
  import rpx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      startCountZero,
  input  logic      cfgDirOut,
  input  logic      countIsOne,
  input  logic      portReady,
  input  logic      memReady,
  output dpStrobe_t strobe,
  output logic      portValid,
  output logic      portWrite,
  output logic      memValid,
  output logic      memWrite,
  output logic      busy,
  output logic      done
);

  seqState_t stateQ, stateD;
  logic      fire;

  // first phase: memory read (output job) or port read (input job)
  // second phase: port write (output job) or memory write (input job)
  always_comb begin
    portValid = 1'b0;
    portWrite = 1'b0;
    memValid  = 1'b0;
    memWrite  = 1'b0;
    if (stateQ == ST_FIRST) begin
      if (cfgDirOut) memValid  = 1'b1;
      else           portValid = 1'b1;
    end else if (stateQ == ST_SECOND) begin
      if (cfgDirOut) begin
        portValid = 1'b1;
        portWrite = 1'b1;
      end else begin
        memValid = 1'b1;
        memWrite = 1'b1;
      end
    end
  end

  assign fire = (portValid && portReady) || (memValid && memReady);

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          strobe.loadCfg = 1'b1;
          stateD = startCountZero ? ST_FIN : ST_FIRST;
        end
      end
      ST_FIRST: begin
        if (fire) begin
          strobe.captureData = 1'b1;
          stateD = ST_SECOND;
        end
      end
      ST_SECOND: begin
        if (fire) begin
          strobe.stepElem = 1'b1;
          stateD = countIsOne ? ST_FIN : ST_FIRST;
        end
      end
      ST_FIN:  stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign busy = (stateQ != ST_IDLE);
  assign done = (stateQ == ST_FIN);

  // R6: a raised request is held until the responder accepts it
  a_r6_port_hold: assert property (@(posedge clk) disable iff (!rstN)
    (portValid && !portReady) |=> (portValid && $stable(portWrite)));
  a_r6_mem_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memWrite)));

endmodule

// File: rtl/rpx_datapath.sv
module rpx_datapath
  import rpx_pkg::*;
#(
  parameter int PORT_W = 16,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              dirOut,
  input  logic [1:0]        sizeSel,
  input  logic              downFlag,
  input  logic [PORT_W-1:0] portNum,
  input  logic [ADDR_W-1:0] ptrStart,
  input  logic [CNT_W-1:0]  countStart,
  input  logic [DATA_W-1:0] portRdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              cfgDirOut,
  output logic              startCountZero,
  output logic              countIsOne,
  output logic [PORT_W-1:0] portAddr,
  output logic [1:0]        xferSize,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              misalign,
  output logic [ADDR_W-1:0] ptrFinal,
  output logic [CNT_W-1:0]  countFinal
);

  localparam int BYTES = DATA_W / 8;

  logic              downQ;
  logic [1:0]        sizeQ;
  logic [PORT_W-1:0] portQ;
  logic [ADDR_W-1:0] ptrQ;
  logic [CNT_W-1:0]  countQ;
  logic [DATA_W-1:0] dataQ;
  logic              dirQ;
  logic              misQ;
  logic [DATA_W-1:0] laneMask;
  logic [DATA_W-1:0] rdSel;
  logic [ADDR_W-1:0] stepAmt;
  logic              misNext;

  // byte-lane mask for the latched element width
  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign laneMask[b*8 +: 8] = (b < int'(elemBytes(sizeQ))) ? 8'hFF : 8'h00;
  end

  assign rdSel   = dirQ ? memRdata : portRdata;
  assign stepAmt = ADDR_W'(elemBytes(sizeQ));

  always_comb begin
    unique case (sizeSel)
      2'd0:    misNext = 1'b0;
      2'd1:    misNext = portNum[0];
      default: misNext = |portNum[1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirQ   <= 1'b0;
      downQ  <= 1'b0;
      sizeQ  <= 2'd0;
      portQ  <= '0;
      ptrQ   <= '0;
      countQ <= '0;
      dataQ  <= '0;
      misQ   <= 1'b0;
    end else if (strobe.loadCfg) begin
      dirQ   <= dirOut;
      downQ  <= downFlag;
      sizeQ  <= sizeSel;
      portQ  <= portNum;
      ptrQ   <= ptrStart;
      countQ <= countStart;
      dataQ  <= '0;
      misQ   <= misNext;
    end else begin
      if (strobe.captureData) dataQ <= rdSel & laneMask;
      if (strobe.stepElem) begin
        ptrQ   <= downQ ? (ptrQ - stepAmt) : (ptrQ + stepAmt);
        countQ <= countQ - CNT_W'(1);
      end
    end
  end

  assign cfgDirOut      = dirQ;
  assign startCountZero = (countStart == '0);
  assign countIsOne     = (countQ == CNT_W'(1));
  assign portAddr       = portQ;
  assign xferSize       = sizeQ;
  assign memAddr        = ptrQ;
  assign wrData         = dataQ;
  assign misalign       = misQ;
  assign ptrFinal       = ptrQ;
  assign countFinal     = countQ;

  // R10: a one-byte job never carries data above the low byte
  a_r10_byte_mask: assert property (@(posedge clk) disable iff (!rstN)
    (sizeQ == 2'd0) |-> (dataQ[DATA_W-1:8] == '0));

endmodule

// File: rtl/rep_port_xfer.sv
module rep_port_xfer
  import rpx_pkg::*;
#(
  parameter int PORT_W = 16,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              dirOut,
  input  logic [1:0]        sizeSel,
  input  logic              downFlag,
  input  logic [PORT_W-1:0] portNum,
  input  logic [ADDR_W-1:0] ptrStart,
  input  logic [CNT_W-1:0]  countStart,
  output logic              portValid,
  output logic              portWrite,
  output logic [PORT_W-1:0] portAddr,
  output logic [1:0]        portSize,
  output logic [DATA_W-1:0] portWdata,
  input  logic              portReady,
  input  logic [DATA_W-1:0] portRdata,
  output logic              memValid,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [1:0]        memSize,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memReady,
  input  logic [DATA_W-1:0] memRdata,
  output logic              busy,
  output logic              done,
  output logic              misalign,
  output logic [ADDR_W-1:0] ptrFinal,
  output logic [CNT_W-1:0]  countFinal
);

  dpStrobe_t         strobe;
  logic              cfgDirOut;
  logic              startCountZero;
  logic              countIsOne;
  logic [1:0]        xferSize;
  logic [DATA_W-1:0] wrData;

  rpx_control u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .start          (start),
    .startCountZero (startCountZero),
    .cfgDirOut      (cfgDirOut),
    .countIsOne     (countIsOne),
    .portReady      (portReady),
    .memReady       (memReady),
    .strobe         (strobe),
    .portValid      (portValid),
    .portWrite      (portWrite),
    .memValid       (memValid),
    .memWrite       (memWrite),
    .busy           (busy),
    .done           (done)
  );

  rpx_datapath #(
    .PORT_W (PORT_W),
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .dirOut         (dirOut),
    .sizeSel        (sizeSel),
    .downFlag       (downFlag),
    .portNum        (portNum),
    .ptrStart       (ptrStart),
    .countStart     (countStart),
    .portRdata      (portRdata),
    .memRdata       (memRdata),
    .cfgDirOut      (cfgDirOut),
    .startCountZero (startCountZero),
    .countIsOne     (countIsOne),
    .portAddr       (portAddr),
    .xferSize       (xferSize),
    .memAddr        (memAddr),
    .wrData         (wrData),
    .misalign       (misalign),
    .ptrFinal       (ptrFinal),
    .countFinal     (countFinal)
  );

  assign portSize  = xferSize;
  assign memSize   = xferSize;
  assign portWdata = wrData;
  assign memWdata  = wrData;

  // R6: only one bus requested at a time
  a_r6_one_side: assert property (@(posedge clk) disable iff (!rstN)
    !(portValid && memValid));
  // R6: port number fixed while the job runs
  a_r6_port_const: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> $stable(portAddr));
  // R8: completion is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R7: every element consumed by the completion cycle
  a_r7_count_empty: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (countFinal == '0));

endmodule

// File: tb/rep_port_xfer_test.sv
`timescale 1ns/1ps
module rep_port_xfer_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        dirOut = 1'b0;
  logic [1:0]  sizeSel = 2'd0;
  logic        downFlag = 1'b0;
  logic [15:0] portNum = '0;
  logic [31:0] ptrStart = '0;
  logic [31:0] countStart = '0;
  logic        portValid, portWrite, memValid, memWrite;
  logic [15:0] portAddr;
  logic [1:0]  portSize, memSize;
  logic [31:0] portWdata, memWdata, memAddr;
  logic        portReady = 1'b0;
  logic        memReady = 1'b0;
  logic [31:0] portRdata = '0;
  logic [31:0] memRdata = '0;
  logic        busy, done, misalign;
  logic [31:0] ptrFinal, countFinal;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  rep_port_xfer uut (
    .clk(clk), .rstN(rstN), .start(start), .dirOut(dirOut), .sizeSel(sizeSel),
    .downFlag(downFlag), .portNum(portNum), .ptrStart(ptrStart),
    .countStart(countStart), .portValid(portValid), .portWrite(portWrite),
    .portAddr(portAddr), .portSize(portSize), .portWdata(portWdata),
    .portReady(portReady), .portRdata(portRdata), .memValid(memValid),
    .memWrite(memWrite), .memAddr(memAddr), .memSize(memSize),
    .memWdata(memWdata), .memReady(memReady), .memRdata(memRdata),
    .busy(busy), .done(done), .misalign(misalign), .ptrFinal(ptrFinal),
    .countFinal(countFinal)
  );

  typedef struct packed {
    logic        dOut;
    logic [1:0]  size;
    logic        down;
    logic [15:0] port;
    logic [31:0] ptr;
    logic [31:0] cnt;
    logic [31:0] expPtr;
    logic        expMis;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 2'd0, 1'b0, 16'h0060, 32'h0000_1000, 32'd3, 32'h0000_1003, 1'b0},
    '{1'b0, 2'd1, 1'b1, 16'h0071, 32'h0000_2000, 32'd2, 32'h0000_1FFC, 1'b1},
    '{1'b1, 2'd2, 1'b0, 16'h00F4, 32'h0000_3000, 32'd4, 32'h0000_3010, 1'b0},
    '{1'b1, 2'd2, 1'b1, 16'hFFFE, 32'h0000_4000, 32'd2, 32'h0000_3FF8, 1'b1},
    '{1'b1, 2'd0, 1'b1, 16'hFFFF, 32'h0000_0001, 32'd3, 32'hFFFF_FFFE, 1'b0},
    '{1'b0, 2'd3, 1'b0, 16'h0004, 32'h0000_0100, 32'd1, 32'h0000_0104, 1'b0}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] maskOf(input logic [1:0] s);
    return (s == 2'd0) ? 32'h0000_00FF : (s == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] stepOf(input logic [1:0] s);
    return (s == 2'd0) ? 32'd1 : (s == 2'd1) ? 32'd2 : 32'd4;
  endfunction

  // Serve one access. Called at a negedge. Checks the side, write flag,
  // address and (for writes) data, holds ready off for 'delay' cycles,
  // then accepts with rdata.
  task automatic serve(input bit onPort, input bit isWr, input logic [31:0] addr,
                       input logic [31:0] wdata, input int delay,
                       input logic [31:0] rdata, input string req);
    int wait_n = 0;
    while (!(portValid || memValid) && wait_n < 20) begin
      @(negedge clk);
      wait_n++;
    end
    check(onPort ? (portValid && !memValid) : (memValid && !portValid), req,
          {62'd0, portValid, memValid}, {62'd0, onPort, !onPort});
    if (onPort) begin
      check(portWrite == isWr, req, portWrite, isWr);
      check(portAddr == addr[15:0], "R6 port", portAddr, addr[15:0]);
      if (isWr) check(portWdata == wdata, "R10 port data", portWdata, wdata);
    end else begin
      check(memWrite == isWr, req, memWrite, isWr);
      check(memAddr == addr, "R3 mem addr", memAddr, addr);
      if (isWr) check(memWdata == wdata, "R10 mem data", memWdata, wdata);
    end
    for (int d = 0; d < delay; d++) @(negedge clk);
    if (delay > 0)
      check(onPort ? portValid : memValid, "R6 hold", 0, 1);
    portRdata = rdata;
    memRdata  = rdata;
    portReady = onPort;
    memReady  = !onPort;
    @(negedge clk);
    portReady = 1'b0;
    memReady  = 1'b0;
  endtask

  task automatic pulseStart(input vec_t v);
    dirOut = v.dOut; sizeSel = v.size; downFlag = v.down;
    portNum = v.port; ptrStart = v.ptr; countStart = v.cnt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // run a whole job; optionally inject a second start while busy (R1)
  task automatic runJob(input vec_t v, input bit intrude);
    logic [31:0] p, dat;
    pulseStart(v);
    check(busy, "R1 busy", busy, 1);
    if (intrude) begin
      start = 1'b1; ptrStart = 32'hDEAD_0000; countStart = 32'd0; downFlag = !v.down;
      @(negedge clk);
      start = 1'b0;
    end
    p = v.ptr;
    for (int k = 0; k < int'(v.cnt); k++) begin
      dat = 32'hA5C3_0000 | (32'(k) << 4) | 32'h7;
      if (v.dOut) begin
        serve(1'b0, 1'b0, p, 0, k % 2, dat, "R5 mem read first");
        serve(1'b1, 1'b1, {16'd0, v.port}, dat & maskOf(v.size), 0, 0, "R5 port write");
      end else begin
        serve(1'b1, 1'b0, {16'd0, v.port}, 0, k % 2, dat, "R4 port read first");
        serve(1'b0, 1'b1, p, dat & maskOf(v.size), 0, 0, "R4 mem write");
      end
      p = v.down ? p - stepOf(v.size) : p + stepOf(v.size);
    end
    check(done, "R7 done after count elements", done, 1);
    check(ptrFinal == v.expPtr, "R2 R3 final pointer", ptrFinal, v.expPtr);
    check(countFinal == 0, "R7 count empty", countFinal, 0);
    check(misalign == v.expMis, "R9 misalign", misalign, v.expMis);
    @(negedge clk);
    check(!done && !busy, "R8 done one cycle", {done, busy}, 0);
    @(negedge clk);
    check(ptrFinal == v.expPtr && countFinal == 0 && misalign == v.expMis,
          "R8 results held", ptrFinal, v.expPtr);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    vec_t z;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    check(!busy && !done && !portValid && !memValid, "R1 reset idle",
          {busy, done, portValid, memValid}, 0);
    check(ptrFinal == 0 && countFinal == 0 && !misalign, "R8 reset values",
          ptrFinal, 0);

    // table of jobs
    for (int i = 0; i < NVEC; i++) runJob(VECS[i], 1'b0);

    // R1: start while busy is ignored
    runJob(VECS[2], 1'b1);

    // R7: zero count completes at once with no bus activity
    z = '{1'b1, 2'd1, 1'b0, 16'h0033, 32'h0000_5550, 32'd0, 32'h0000_5550, 1'b1};
    pulseStart(z);
    check(done && !portValid && !memValid, "R7 zero count",
          {done, portValid, memValid}, 3'b100);
    check(ptrFinal == 32'h5550 && countFinal == 0, "R7 zero count pointer",
          ptrFinal, 32'h5550);
    check(misalign, "R9 odd port, 2 bytes", misalign, 1);
    @(negedge clk);
    check(!done && !busy, "R8 zero count pulse", {done, busy}, 0);

    // R10: 2-byte job masks high bits, 4-byte up/down already covered
    runJob('{1'b1, 2'd1, 1'b0, 16'h0010, 32'hFFFF_FFFE, 32'd2, 32'h0000_0002, 1'b0}, 1'b0);

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule